// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block keeps two copies of a display controller's configuration: a shadow copy that software writes and reads over a small register port, and an active copy that the scan-out logic uses. The shadow contents move into the active copy only on a clock cycle in which the vertical sync pulse is high. A frame therefore always runs on a complete configuration, never on one that is half rewritten.

The configuration has a group of global fields and a number of window groups, each with several fields. Software arms a transfer by writing 1 to the update-request bit. Every window also has a protect bit. While a window's protect bit is set, that window keeps its pending values through vsync. Once the bit is cleared, those values move across at the next vsync, with no new request needed. The update-request bit reads back as 1 until every armed group has been transferred, and then it clears by itself. Bit 0 of a window's first field is that window's enable. Clearing it only takes effect when the transfer happens, so the window stays on until then.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every shadow and active field is zero, the protect register is zero, the update request is clear and no window is enabled.
- R2: A write to a mapped field updates the shadow copy, which reads back at once at the same address. The active copy is left unchanged until a vsync transfer.
- R3: A vsync cycle with no transfer armed leaves every active field unchanged.
- R4: Writing a word with bit 0 set to address 0 arms a transfer of the global group and of every window. Address 0 then reads back 1 in bit 0 while any group is still waiting. The bit clears by itself once all groups have transferred. Writing 0 to it has no effect.
- R5: In the clock cycle that follows a vsync cycle with a transfer armed, each unprotected window and the global group hold in their active copy the shadow values they had during that vsync cycle.
- R6: Protect bit w lives at address 1, bit w. While it is set, window w's active fields do not change at vsync, and its pending transfer stays armed.
- R7: Once a protected window with a pending transfer is unprotected, its shadow values move to the active copy at the next vsync. No new request is needed.
- R8: The window-enable output for window w is bit 0 of active field 0 of window w. After software clears that bit in the shadow copy, the output stays 1 until the vsync transfer.
- R9: The protect register reads back at address 1 right after it is written, and it acts at once, with no wait for vsync.
- R10: Writes to unmapped addresses change nothing, and reads from them return zero. With the default parameters the global field g is at address 2+g and window w field f is at address 4+4w+f. Addresses 12 and above are unmapped.
- R11: When a shadow write and vsync fall in the same cycle, the active copy takes the value written before that cycle. When an update request and vsync fall in the same cycle, that request stays armed for the following vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync | input | 1 | Frame boundary pulse, sampled on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data from the shadow copy or control bits (combinational) |
| act_glb | output | GLB_REGS*DATA_W | Active global fields, field 0 in the low bits |
| act_win | output | NUM_WIN*WIN_FIELDS*DATA_W | Active window fields, index w*WIN_FIELDS+f |
| win_on | output | NUM_WIN | Active enable bit of each window |
| upd_busy | output | 1 | A transfer is still armed for some group |

## Verification
The hardest case to reach is a window whose transfer is still pending while another window has already transferred on the same request. The stimulus protects window 0, arms a request covering both windows, and passes two vsync pulses. It checks that window 1 moved, that window 0 did not, and that the request bit still reads 1. It then unprotects window 0 and sends a vsync with no fresh request. Two same-cycle collisions are driven in one negedge slot: a shadow write together with vsync, and a request together with vsync. These expose any off-by-one-cycle ordering between the shadow capture and the transfer.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
   localparam int UPD_ADDR  = 0;
   localparam int PROT_ADDR = 1;
   localparam int GLB_BASE  = 2;
   localparam int UPD_BIT   = 0;

   // address stride between window groups: fields rounded up to a power of two
   function automatic int win_stride(input int fields);
      return 1 << $clog2(fields);
   endfunction

   // first window address: the control and global area rounded up to a power of two
   function automatic int win_base(input int glb_regs);
      return 1 << $clog2(GLB_BASE + glb_regs);
   endfunction
endpackage

// File: rtl/vsb_decode.sv
module vsb_decode #(
   parameter int ADDR_W     = 6,
   parameter int NUM_WIN    = 2,
   parameter int WIN_FIELDS = 4,
   parameter int GLB_REGS   = 2
) (
   input  logic [ADDR_W-1:0]             addr,
   output logic                          upd_sel,
   output logic                          prot_sel,
   output logic [GLB_REGS-1:0]           glb_sel,
   output logic [NUM_WIN*WIN_FIELDS-1:0] win_sel
);
   localparam int STRIDE = vsb_pkg::win_stride(WIN_FIELDS);
   localparam int WBASE  = vsb_pkg::win_base(GLB_REGS);

   assign upd_sel  = (addr == ADDR_W'(vsb_pkg::UPD_ADDR));
   assign prot_sel = (addr == ADDR_W'(vsb_pkg::PROT_ADDR));

   for (genvar g = 0; g < GLB_REGS; g++) begin : g_glb
      assign glb_sel[g] = (addr == ADDR_W'(vsb_pkg::GLB_BASE + g));
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      for (genvar f = 0; f < WIN_FIELDS; f++) begin : g_fld
         assign win_sel[w*WIN_FIELDS + f] = (addr == ADDR_W'(WBASE + w*STRIDE + f));
      end
   end
endmodule

// File: rtl/vsb_group.sv
module vsb_group #(
   parameter int DATA_W = 32,
   parameter int FIELDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vsync,
   input  logic                     arm,
   input  logic                     protect,
   input  logic                     wr_en,
   input  logic [FIELDS-1:0]        wr_sel,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [FIELDS*DATA_W-1:0] shadow,
   output logic [FIELDS*DATA_W-1:0] active,
   output logic                     pending
);
   logic [DATA_W-1:0] shd_q [FIELDS];
   logic [DATA_W-1:0] act_q [FIELDS];
   logic              pend_q;
   logic              xfer;

   // a transfer needs the frame boundary, an armed request and no protection
   assign xfer = vsync & pend_q & ~protect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < FIELDS; i++) begin
            shd_q[i] <= '0;
            act_q[i] <= '0;
         end
         pend_q <= 1'b0;
      end else begin
         for (int i = 0; i < FIELDS; i++) begin
            if (wr_en && wr_sel[i]) shd_q[i] <= wr_data;
            if (xfer)               act_q[i] <= shd_q[i];
         end
         pend_q <= (pend_q & ~xfer) | arm;
      end
   end

   for (genvar i = 0; i < FIELDS; i++) begin : g_flat
      assign shadow[i*DATA_W +: DATA_W] = shd_q[i];
      assign active[i*DATA_W +: DATA_W] = act_q[i];
   end

   assign pending = pend_q;
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
   parameter int DATA_W     = 32,
   parameter int NUM_WIN    = 2,
   parameter int WIN_FIELDS = 4,
   parameter int GLB_REGS   = 2,
   parameter int ADDR_W     = 6,
   parameter int EN_BIT     = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 vsync,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [DATA_W-1:0]                    wr_data,
   input  logic [ADDR_W-1:0]                    rd_addr,
   output logic [DATA_W-1:0]                    rd_data,
   output logic [GLB_REGS*DATA_W-1:0]           act_glb,
   output logic [NUM_WIN*WIN_FIELDS*DATA_W-1:0] act_win,
   output logic [NUM_WIN-1:0]                   win_on,
   output logic                                 upd_busy
);
   localparam int STRIDE   = vsb_pkg::win_stride(WIN_FIELDS);
   localparam int WBASE    = vsb_pkg::win_base(GLB_REGS);
   localparam int MAP_END  = WBASE + NUM_WIN*STRIDE;
   localparam int WF_TOTAL = NUM_WIN*WIN_FIELDS;
   localparam int GRP_W    = WIN_FIELDS*DATA_W;

   // elaboration-time parameter checks
   if (NUM_WIN < 1 || NUM_WIN > DATA_W) begin : g_bad_num_win
      $error("NUM_WIN must lie in 1..DATA_W");
   end
   if (WIN_FIELDS < 1 || GLB_REGS < 1) begin : g_bad_fields
      $error("WIN_FIELDS and GLB_REGS must be at least 1");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en_bit
      $error("EN_BIT must fall inside DATA_W");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   // write and read decode
   logic                w_upd, w_prot, r_upd, r_prot;
   logic [GLB_REGS-1:0] w_glb, r_glb;
   logic [WF_TOTAL-1:0] w_win, r_win;

   vsb_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_FIELDS(WIN_FIELDS),
                .GLB_REGS(GLB_REGS)) u_wr_dec (
      .addr(wr_addr), .upd_sel(w_upd), .prot_sel(w_prot),
      .glb_sel(w_glb), .win_sel(w_win));

   vsb_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_FIELDS(WIN_FIELDS),
                .GLB_REGS(GLB_REGS)) u_rd_dec (
      .addr(rd_addr), .upd_sel(r_upd), .prot_sel(r_prot),
      .glb_sel(r_glb), .win_sel(r_win));

   // request arming and protect register
   logic               arm;
   logic [NUM_WIN-1:0] prot_q;

   assign arm = wr_en & w_upd & wr_data[vsb_pkg::UPD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              prot_q <= '0;
      else if (wr_en && w_prot) prot_q <= wr_data[NUM_WIN-1:0];
   end

   // global group: never protected
   logic [GLB_REGS*DATA_W-1:0] shd_glb;
   logic                       pend_glb;

   vsb_group #(.DATA_W(DATA_W), .FIELDS(GLB_REGS)) u_glb (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .arm(arm), .protect(1'b0),
      .wr_en(wr_en), .wr_sel(w_glb), .wr_data(wr_data),
      .shadow(shd_glb), .active(act_glb), .pending(pend_glb));

   // window groups
   logic [WF_TOTAL*DATA_W-1:0] shd_win;
   logic [NUM_WIN-1:0]         pend_win;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      vsb_group #(.DATA_W(DATA_W), .FIELDS(WIN_FIELDS)) u_grp (
         .clk(clk), .rst_n(rst_n), .vsync(vsync), .arm(arm), .protect(prot_q[w]),
         .wr_en(wr_en), .wr_sel(w_win[w*WIN_FIELDS +: WIN_FIELDS]), .wr_data(wr_data),
         .shadow(shd_win[w*GRP_W +: GRP_W]), .active(act_win[w*GRP_W +: GRP_W]),
         .pending(pend_win[w]));
      assign win_on[w] = act_win[w*GRP_W + EN_BIT];
   end

   assign upd_busy = pend_glb | (|pend_win);

   // read mux over shadow copies and control bits
   always_comb begin
      rd_data = '0;
      if (r_upd)  rd_data[vsb_pkg::UPD_BIT] = upd_busy;
      if (r_prot) rd_data[NUM_WIN-1:0]      = prot_q;
      for (int g = 0; g < GLB_REGS; g++)
         if (r_glb[g]) rd_data = rd_data | shd_glb[g*DATA_W +: DATA_W];
      for (int i = 0; i < WF_TOTAL; i++)
         if (r_win[i]) rd_data = rd_data | shd_win[i*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
   parameter int DATA_W     = 32,
   parameter int NUM_WIN    = 2,
   parameter int WIN_FIELDS = 4,
   parameter int GLB_REGS   = 2,
   parameter int ADDR_W     = 6
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 vsync,
   input logic                                 wr_en,
   input logic [ADDR_W-1:0]                    wr_addr,
   input logic                                 wr_bit0,
   input logic [NUM_WIN-1:0]                   prot,
   input logic [GLB_REGS*DATA_W-1:0]           act_glb,
   input logic [NUM_WIN*WIN_FIELDS*DATA_W-1:0] act_win,
   input logic [NUM_WIN-1:0]                   win_on,
   input logic                                 upd_busy
);
   localparam int GRP_W = WIN_FIELDS*DATA_W;

   logic req_wr;
   assign req_wr = wr_en && (wr_addr == ADDR_W'(0)) && wr_bit0;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (win_on == '0 && !upd_busy && act_win == '0 && act_glb == '0));

   assert_hold_between_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> ($stable(act_win) && $stable(act_glb) && $stable(win_on)));

   assert_unarmed_vsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !upd_busy) |=> ($stable(act_win) && $stable(act_glb)));

   assert_request_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |=> upd_busy);

   assert_request_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && upd_busy && prot == '0 && !req_wr) |=> !upd_busy);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_prot
      assert_protect_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (vsync && prot[w]) |=> $stable(act_win[w*GRP_W +: GRP_W]));
   end
endmodule

bind vsync_shadow_bank vsb_checker #(
   .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_FIELDS(WIN_FIELDS),
   .GLB_REGS(GLB_REGS), .ADDR_W(ADDR_W)
) u_vsb_checker (
   .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_bit0(wr_data[0]), .prot(prot_q), .act_glb(act_glb), .act_win(act_win),
   .win_on(win_on), .upd_busy(upd_busy)
);

// File: tb/vsync_shadow_bank_bench.sv
module vsync_shadow_bank_bench;
   localparam int DW = 32;
   localparam int NW = 2;
   localparam int NF = 4;
   localparam int NG = 2;
   localparam int AW = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               vsync = 1'b0;
   logic               wr_en = 1'b0;
   logic [AW-1:0]      wr_addr = '0;
   logic [DW-1:0]      wr_data = '0;
   logic [AW-1:0]      rd_addr = '0;
   logic [DW-1:0]      rd_data;
   logic [NG*DW-1:0]   act_glb;
   logic [NW*NF*DW-1:0] act_win;
   logic [NW-1:0]      win_on;
   logic               upd_busy;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   vsync_shadow_bank u_vsync_shadow_bank (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .act_glb(act_glb),
      .act_win(act_win), .win_on(win_on), .upd_busy(upd_busy));

   localparam logic [DW-1:0] VA = 32'hA5A5_0001;
   localparam logic [DW-1:0] VB = 32'h0B0B_0002;
   localparam logic [DW-1:0] VC = 32'h0C0C_0003;
   localparam logic [DW-1:0] VD = 32'h0D0D_0004;
   localparam logic [DW-1:0] VE = 32'h0E0E_0005;

   function automatic logic [AW-1:0] waddr(input int w, input int f);
      return AW'(4 + 4*w + f);
   endfunction

   function automatic logic [DW-1:0] aw(input int w, input int f);
      return act_win[(w*NF + f)*DW +: DW];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [AW-1:0] a,
                           input logic [DW-1:0] exp);
      rd_addr = a;
      #1;
      check(tag, $sformatf("read @%0d", a), rd_data, exp);
   endtask

   task automatic pulse_vsync();
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
   endtask

   // vsync and a register write in the same cycle
   task automatic vsync_with_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      vsync = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      vsync = 1'b0; wr_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "win_on", DW'(win_on), '0);
      check("R1", "upd_busy", DW'(upd_busy), '0);
      check("R1", "act_win0 f0", aw(0, 0), '0);
      check("R1", "act_glb0", act_glb[DW-1:0], '0);
      rd_check("R1", 0, '0);
      rd_check("R1", 1, '0);
      rd_check("R1", waddr(1, 3), '0);
   endtask

   task automatic t_shadow_only();
      wr(waddr(0, 1), VA);
      rd_check("R2", waddr(0, 1), VA);
      check("R2", "active before vsync", aw(0, 1), '0);
      pulse_vsync();
      check("R3", "active after unarmed vsync", aw(0, 1), '0);
      check("R3", "upd_busy", DW'(upd_busy), '0);
   endtask

   task automatic t_commit();
      wr(waddr(0, 0), 32'h1);
      wr(waddr(1, 0), 32'h1);
      wr(AW'(2), 32'h1234);
      wr(AW'(0), 32'h1);
      rd_check("R4", 0, 32'h1);
      check("R5", "win_on before vsync", DW'(win_on), '0);
      pulse_vsync();
      check("R5", "act w0 f0", aw(0, 0), 32'h1);
      check("R5", "act w0 f1", aw(0, 1), VA);
      check("R5", "act w1 f0", aw(1, 0), 32'h1);
      check("R5", "act glb0", act_glb[DW-1:0], 32'h1234);
      check("R5", "win_on", DW'(win_on), 32'h3);
      rd_check("R4", 0, '0);
      wr(AW'(0), 32'h0);
      rd_check("R4", 0, '0);
   endtask

   task automatic t_protect();
      wr(AW'(1), 32'h1);
      rd_check("R9", 1, 32'h1);
      wr(waddr(0, 2), VB);
      wr(waddr(1, 2), VC);
      wr(AW'(0), 32'h1);
      pulse_vsync();
      check("R5", "unprotected w1 f2", aw(1, 2), VC);
      check("R6", "protected w0 f2", aw(0, 2), '0);
      check("R6", "request still armed", DW'(upd_busy), 32'h1);
      pulse_vsync();
      check("R6", "protected w0 f2 second vsync", aw(0, 2), '0);
      wr(AW'(1), 32'h0);
      rd_check("R9", 1, '0);
      pulse_vsync();
      check("R7", "w0 f2 after unprotect", aw(0, 2), VB);
      check("R7", "upd_busy", DW'(upd_busy), '0);
   endtask

   task automatic t_disable();
      wr(waddr(1, 0), 32'h0);
      repeat (3) @(negedge clk);
      check("R8", "win_on after shadow clear", DW'(win_on), 32'h3);
      wr(AW'(0), 32'h1);
      check("R8", "win_on armed, pre vsync", DW'(win_on), 32'h3);
      pulse_vsync();
      check("R8", "win_on after vsync", DW'(win_on), 32'h1);
   endtask

   task automatic t_unmapped();
      wr(AW'(6'h30), 32'hFFFF_FFFF);
      rd_check("R10", AW'(6'h30), '0);
      rd_check("R10", waddr(0, 1), VA);
      rd_check("R10", 1, '0);
      check("R10", "upd_busy", DW'(upd_busy), '0);
      pulse_vsync();
      check("R10", "act w0 f1", aw(0, 1), VA);
      check("R10", "win_on", DW'(win_on), 32'h1);
   endtask

   task automatic t_collide();
      wr(waddr(0, 3), VD);
      wr(AW'(0), 32'h1);
      vsync_with_write(waddr(0, 3), VE);
      check("R11", "active takes pre-write value", aw(0, 3), VD);
      rd_check("R11", waddr(0, 3), VE);
      check("R11", "busy after transfer", DW'(upd_busy), '0);
      vsync_with_write(AW'(0), 32'h1);
      check("R11", "request kept armed", DW'(upd_busy), 32'h1);
      check("R11", "active unchanged", aw(0, 3), VD);
      pulse_vsync();
      check("R11", "late request transfer", aw(0, 3), VE);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_shadow_only();
      t_commit();
      t_protect();
      t_disable();
      t_unmapped();
      t_collide();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule